// File: doc/BRIEF.md
# Compare Timer with Shared Interrupt Vector

This block is a free-running up-counter with three compare channels and a wrap event. It serves two interrupt lines. Compare channel 0 owns a private, higher-priority line that is cleared by an acknowledge pulse from the interrupt controller. Compare channels 1 and 2 and the wrap event share a second line. Software finds the cause of the shared line by reading a vector register. That read returns a small code for the highest-priority source that is both pending and enabled. It also clears that one source, so a handler can loop on the vector until it reads zero.

The counter runs from zero up to the limit held in compare register 0, then returns to zero. It advances either on every clock or on every eighth clock. A simple register bus sets the compare values, the enables and the run control. The same bus reads back the count, the flags and the vector.

Top module: `tmr_vec_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the counter is stopped, and both interrupt outputs are low.
- R2: While running, the count goes up by one per tick. On the tick where it equals compare register 0, it returns to 0. While stopped, it holds its value.
- R3: Control bit 1 selects division by 8, so the count advances on every eighth clock. Otherwise it advances on every clock. Writing control with bit 2 set zeroes the counter and the divider in that cycle, and bit 2 reads back as 0.
- R4: The flag of compare channel k sets on the clock edge where the counter takes the value of compare register k. The flags read at address 5: bit 0 is channel 0, bit 1 is channel 1, bit 2 is channel 2, and bit 3 is the wrap flag.
- R5: The wrap flag (bit 3) sets on the edge where the counter returns from the compare register 0 value to 0.
- R6: `irq_ch0` equals flag 0 AND enable bit 0. A cycle with `irq0_ack` high clears flag 0. Vector reads never clear flag 0.
- R7: `irq_shr` is high exactly when at least one of channel 1, channel 2 or wrap has its flag set and its enable bit set. The enable bits sit at address 4: bit 1 for channel 1, bit 2 for channel 2, bit 3 for wrap.
- R8: The vector at address 7 reads 2 for channel 1, 4 for channel 2, 10 for wrap, and 0 for none. Channel 1 has the highest priority and wrap the lowest. A pending flag whose enable bit is clear is ignored by the vector.
- R9: A read of address 7 clears only the flag whose code it returned. Any other pending enabled shared flag keeps `irq_shr` high in the next cycle. Reads of other addresses change nothing.
- R10: When a flag-set event meets a clear in the same cycle, from either `irq0_ack` or a vector read, the flag ends up set.
- R11: The register map is: address 0 is control (bit 0 run, bit 1 divide by 8, bit 2 clear), addresses 1 to 3 are compare registers 0 to 2, address 4 is the enables, address 6 is the count. Writes take effect on the next edge and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has an effect only at address 7) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq0_ack | input | 1 | Acknowledge of the channel 0 interrupt |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_shr | output | 1 | Shared interrupt for channel 1, channel 2 and wrap |

## Verification
A corrupted flag or enable appears on an interrupt line in the same cycle and in the vector value on the next read. A wrong count appears at the next compare or wrap edge, as a flag that sets early, sets late or never sets. A clear that removes the wrong flag leaves `irq_shr` high or low one cycle after the vector read. The per-cycle comparison of both lines and of every read value against the behavioural model therefore catches such faults within one period of the counter.

// File: rtl/tmr_pkg.sv
// Shared constants for the compare timer: register addresses, source
// indices and vector codes. Assumes exactly three compare channels.
package tmr_pkg;
    localparam int NCH  = 3;          // compare channels
    localparam int NSRC = NCH + 1;    // channels plus the wrap source
    localparam int SRC_WRAP = NCH;    // index of the wrap flag

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_CMP0 = 1;
    localparam int A_EN   = 4;
    localparam int A_FLAG = 5;
    localparam int A_CNT  = 6;
    localparam int A_VEC  = 7;

    // control bit positions
    localparam int C_RUN  = 0;
    localparam int C_DIV  = 1;
    localparam int C_CLR  = 2;

    localparam logic [3:0] VEC_NONE = 4'd0;
    localparam logic [3:0] VEC_WRAP = 4'd10;

    // vector code for a shared source index (1..NSRC-1)
    function automatic logic [3:0] src_code(input int s);
        if (s == SRC_WRAP) return VEC_WRAP;
        return 4'(2 * s);
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
// Input clock divider. Produces a one-cycle tick on every clock, or on
// every 2**DIV_LOG2 clocks when div_en is set. restart zeroes the phase
// and suppresses the tick in that cycle. Assumes run and div_en are
// registered control bits.
module tmr_prescale #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_en,
    input  logic restart,
    output logic tick
);
    logic [DIV_LOG2-1:0] phase_q;

    // advance the divider phase while running
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= phase_q + 1'b1;
    end

    // tick on every clock, or only at the last phase when dividing
    always_comb tick = run && !restart && (!div_en || (&phase_q));

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_en) |=> (!tick || !div_en)); // R3
endmodule

// File: rtl/tmr_count.sv
// Up counter that runs from 0 to limit and returns to 0. It advances
// only on tick, and restart forces it to 0. It exports the next value so
// the compare logic can set flags on the same edge as the count update.
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    // wrap event: a tick while sitting on the limit
    always_comb wrap = tick && (cnt == limit);

    // next-count selection
    always_comb begin
        if (restart)   cnt_nxt = '0;
        else if (wrap) cnt_nxt = '0;
        else if (tick) cnt_nxt = cnt + 1'b1;
        else           cnt_nxt = cnt;
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R5
endmodule

// File: rtl/tmr_flags.sv
// Flag bank. Compare channel k sets its flag when the counter takes the
// value of compare register k. The wrap event sets the last flag. A set
// beats a clear in the same cycle. Assumes clr arrives as one bit per
// source.
module tmr_flags
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           cnt_nxt,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp,
    input  logic                       wrap,
    input  logic [NSRC-1:0]            clr,
    output logic [NSRC-1:0]            flags
);
    logic [NSRC-1:0] set;

    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        // compare hit on the edge where the count becomes cmp[k]
        always_comb set[k] = tick && (cnt_nxt == cmp[k]);
    end
    // wrap source
    always_comb set[SRC_WRAP] = wrap;

    for (genvar k = 0; k < NSRC; k++) begin : g_flag
        // sticky flag, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[k] <= 1'b0;
            else if (set[k]) flags[k] <= 1'b1;
            else if (clr[k]) flags[k] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[k] |=> flags[k]); // R10
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !set[k]) |=> !flags[k]); // R9
    end
endmodule

// File: rtl/tmr_vecarb.sv
// Vector arbiter for the shared interrupt line. It picks the
// lowest-index pending, enabled shared source (index 1 upward), reports
// its code and, on a vector read, requests a clear of that source only.
// Source 0 is never touched.
module tmr_vecarb
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] en,
    input  logic            rd_vec,
    output logic [3:0]      vec,
    output logic            irq_shr,
    output logic [NSRC-1:0] clr
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] sel;

    // pending and enabled sources
    always_comb pend = flags & en;

    // fixed priority: lowest shared index wins
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int s = 1; s < NSRC; s++) begin
            if (pend[s] && !found) begin
                sel[s] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // code of the selected source
    always_comb begin
        vec = VEC_NONE;
        for (int s = 1; s < NSRC; s++) begin
            if (sel[s]) vec = src_code(s);
        end
    end

    // shared request line and read-triggered clear
    always_comb irq_shr = |pend[NSRC-1:1];
    always_comb clr     = rd_vec ? sel : '0;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R8
    AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shr == (vec != VEC_NONE)); // R7
endmodule

// File: rtl/tmr_vec_unit.sv
// Top level of the compare timer. Holds the bus-visible registers, joins
// the divider, counter, flag bank and vector arbiter, and drives both
// interrupt lines. Reads are combinational. Only a read of the vector
// address has a side effect. Assumes single-cycle strobes.
module tmr_vec_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_LOG2 = 3,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              irq0_ack,
    output logic              irq_ch0,
    output logic              irq_shr
);
    logic                      run_q;
    logic                      div_q;
    logic [NCH-1:0][CNT_W-1:0] cmp_q;
    logic [NSRC-1:0]           en_q;

    logic                      wr_ctrl;
    logic                      restart;
    logic                      rd_vec;
    logic                      tick;
    logic [CNT_W-1:0]          cnt;
    logic [CNT_W-1:0]          cnt_nxt;
    logic                      wrap;
    logic [NSRC-1:0]           flags;
    logic [NSRC-1:0]           clr;
    logic [NSRC-1:0]           clr_shr;
    logic [3:0]                vec;

    // decoded strobes
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
        restart = wr_ctrl && bus_wdata[C_CLR];
        rd_vec  = bus_rd && (bus_addr == ADDR_W'(A_VEC));
    end

    // control and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= 1'b0;
            en_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= bus_wdata[C_RUN];
                div_q <= bus_wdata[C_DIV];
            end
            if (bus_wr && (bus_addr == ADDR_W'(A_EN)))
                en_q <= bus_wdata[NSRC-1:0];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_cmpreg
        // compare register k
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[k] <= '0;
            else if (bus_wr && (bus_addr == ADDR_W'(A_CMP0 + k)))
                cmp_q[k] <= bus_wdata;
        end
    end

    tmr_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .div_en  (div_q),
        .restart (restart),
        .tick    (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .limit   (cmp_q[0]),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    // clear sources: acknowledge for channel 0, vector read for the rest
    always_comb begin
        clr    = clr_shr;
        clr[0] = irq0_ack;
    end

    tmr_flags #(.CNT_W(CNT_W)) u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_nxt (cnt_nxt),
        .cmp     (cmp_q),
        .wrap    (wrap),
        .clr     (clr),
        .flags   (flags)
    );

    tmr_vecarb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .en      (en_q),
        .rd_vec  (rd_vec),
        .vec     (vec),
        .irq_shr (irq_shr),
        .clr     (clr_shr)
    );

    // private channel 0 line
    always_comb irq_ch0 = flags[0] && en_q[0];

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_CTRL: begin
                bus_rdata[C_RUN] = run_q;
                bus_rdata[C_DIV] = div_q;
            end
            A_CMP0, A_CMP0 + 1, A_CMP0 + 2:
                bus_rdata = cmp_q[int'(bus_addr) - A_CMP0];
            A_EN:   bus_rdata[NSRC-1:0] = en_q;
            A_FLAG: bus_rdata[NSRC-1:0] = flags;
            A_CNT:  bus_rdata = cnt;
            A_VEC:  bus_rdata[3:0] = vec;
            default: bus_rdata = '0;
        endcase
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0_ack && !(tick && cnt_nxt == cmp_q[0])) |=> !irq_ch0); // R6
    AST_VEC_KEEPS0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !irq0_ack && flags[0]) |=> flags[0]); // R6
endmodule

// File: tb/tmr_vec_unit_tb.sv
`timescale 1ns/1ps
module tmr_vec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq0_ack = 1'b0;
    logic        irq_ch0;
    logic        irq_shr;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;

    // behavioural reference state
    int m_cnt, m_p;
    bit m_run, m_div;
    int m_cmp[3];
    bit m_f[4];
    bit m_en[4];

    always #2.5 clk = ~clk;

    tmr_vec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq0_ack(irq0_ack), .irq_ch0(irq_ch0), .irq_shr(irq_shr)
    );

    function automatic void chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endfunction

    function automatic int m_vec();
        if (m_f[1] && m_en[1]) return 2;
        if (m_f[2] && m_en[2]) return 4;
        if (m_f[3] && m_en[3]) return 10;
        return 0;
    endfunction

    function automatic int m_read(int a);
        int v;
        v = 0;
        case (a)
            0: v = int'(m_run) + 2 * int'(m_div);
            1, 2, 3: v = m_cmp[a-1];
            4: for (int i = 0; i < 4; i++) v += int'(m_en[i]) << i;
            5: for (int i = 0; i < 4; i++) v += int'(m_f[i]) << i;
            6: v = m_cnt;
            7: v = m_vec();
            default: v = 0;
        endcase
        return v;
    endfunction

    // reference model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_p = 0; m_run = 0; m_div = 0;
            for (int i = 0; i < 3; i++) m_cmp[i] = 0;
            for (int i = 0; i < 4; i++) begin m_f[i] = 0; m_en[i] = 0; end
        end else begin
            bit restart, tick, wrap, st, cl;
            int nc, v;
            restart = bus_wr && bus_addr == 0 && bus_wdata[2];
            tick = m_run && !restart && (!m_div || m_p == 7);
            wrap = tick && m_cnt == m_cmp[0];
            if (restart) nc = 0;
            else if (wrap) nc = 0;
            else if (tick) nc = (m_cnt + 1) % 65536;
            else nc = m_cnt;
            v = m_vec();
            for (int k = 0; k < 4; k++) begin
                st = (k < 3) ? (tick && nc == m_cmp[k]) : wrap;
                if (k == 0) cl = irq0_ack;
                else cl = bus_rd && bus_addr == 7 && v == ((k == 3) ? 10 : 2 * k);
                m_f[k] = st || (m_f[k] && !cl);
            end
            if (restart) m_p = 0;
            else if (m_run) m_p = (m_p + 1) % 8;
            m_cnt = nc;
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: begin m_run = bus_wdata[0]; m_div = bus_wdata[1]; end
                    1, 2, 3: m_cmp[bus_addr-1] = int'(bus_wdata);
                    4: for (int i = 0; i < 4; i++) m_en[i] = bus_wdata[i];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(irq0_ack ? "R10 irq_ch0" : "R6 irq_ch0", int'(irq_ch0),
                int'(m_f[0] && m_en[0]));
            chk("R7 irq_shr", int'(irq_shr), int'(m_vec() != 0));
            if (bus_rd) begin
                case (int'(bus_addr))
                    7: chk("R9 vector", int'(bus_rdata), m_read(7));
                    6: chk("R2 count", int'(bus_rdata), m_read(6));
                    5: chk("R4 flags", int'(bus_rdata), m_read(5));
                    default: chk("R11 reg", int'(bus_rdata), m_read(int'(bus_addr)));
                endcase
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(posedge clk); #1;
        bus_rd = 1; bus_addr = 3'(a);
        @(negedge clk);
        chk(tag, int'(bus_rdata), exp);
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3); #1;
        rst_n = 1; started = 1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 reset read");
        @(negedge clk);
        chk("R1 irq_ch0", int'(irq_ch0), 0);
        chk("R1 irq_shr", int'(irq_shr), 0);

        // R11 configuration and readback
        wr(1, 9); wr(2, 3); wr(3, 6); wr(4, 15);
        rd_chk(1, 9, "R11 cmp0");
        rd_chk(3, 6, "R11 cmp2");
        rd_chk(4, 15, "R11 enables");

        // R2/R4/R5 run at full rate from a cleared counter
        wr(0, 5);
        rd_chk(0, 1, "R3 clear bit reads 0");
        rd_chk(5, 2, "R4 channel 1 flag at count 3");
        idle(3);
        rd_chk(6, 8, "R2 count");
        rd_chk(6, 0, "R2 wrap to zero");
        rd_chk(5, 15, "R5 wrap flag");
        idle(10);
        wr(0, 0);
        rd_chk(6, m_cnt, "R2 hold");
        idle(4);
        rd_chk(6, m_cnt, "R2 hold");

        // R6 acknowledge clears channel 0 only
        @(negedge clk);
        chk("R6 irq_ch0 pending", int'(irq_ch0), 1);
        @(posedge clk); #1; irq0_ack = 1;
        @(posedge clk); #1; irq0_ack = 0;
        @(negedge clk);
        chk("R6 irq_ch0 after ack", int'(irq_ch0), 0);

        // R8/R9 vector sequence
        rd_chk(7, 2, "R9 vector ch1");
        @(negedge clk);
        chk("R9 irq_shr stays", int'(irq_shr), 1);
        rd_chk(7, 4, "R9 vector ch2");
        rd_chk(5, 8, "R9 only wrap left");
        rd_chk(7, 10, "R8 vector wrap");
        rd_chk(7, 0, "R8 vector none");
        @(negedge clk);
        chk("R7 irq_shr low", int'(irq_shr), 0);

        // R8 disabled source is ignored
        wr(0, 5); idle(25); wr(0, 0);
        wr(4, 13);
        rd_chk(7, 4, "R8 skip disabled ch1");
        rd_chk(5, 11, "R8 flags after read");
        rd_chk(7, 10, "R8 vector wrap");
        rd_chk(7, 0, "R8 disabled pending ignored");
        rd_chk(5, 3, "R8 ch1 still set");
        @(negedge clk);
        chk("R7 irq_shr gated", int'(irq_shr), 0);
        wr(4, 15);
        @(negedge clk);
        chk("R7 irq_shr enabled", int'(irq_shr), 1);
        rd_chk(7, 2, "R7 vector ch1");

        // R3 divide by eight
        wr(0, 7);
        idle(19);
        rd_chk(6, 2, "R3 divided count");
        idle(60);

        // R10 set beats clear: ack and vector reads held every cycle
        wr(0, 5);
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            irq0_ack = 1; bus_rd = 1; bus_addr = 3'd7;
        end
        @(posedge clk); #1;
        irq0_ack = 0; bus_rd = 0;
        wr(0, 0);
        rd_chk(5, m_read(5), "R10 flags after held clears");
        idle(2);
        finish_run();
    end
endmodule